// File: doc/BRIEF.md
# Pipelined DES Block Encryptor

This block encrypts 64-bit blocks with the Data Encryption Standard, using one registered pipeline stage for each of the sixteen Feistel rounds. Plaintext arrives as a stream of narrow words over a word-valid port. A gathering register packs the words into a full block and launches that block into the round pipeline as soon as its last word is accepted. The pipeline accepts a new block on every clock and holds up to sixteen blocks in flight. A valid flag travels with each block, so the output flags exactly the cycles that carry real ciphertext.

The key is loaded once with a single strobe. All sixteen round keys are then derived and held in registers, and they are reused for every block until the next load. A key load is allowed only while the pipeline is empty. The input word width is a parameter: an 8-bit port gives the narrow streaming interface, and a 64-bit port delivers a full block every clock.

Top module: `des_pipe_engine`

## Requirements
- R1: While rst_ni is low, and after it is released, ct_valid_o is 0 and ct_o is all zeros. Reset discards any partially gathered block and clears the stored round keys.
- R2: Input words are packed most-significant first. The first accepted word lands in bits 63:56 when IN_W is 8. A block is launched on the edge that accepts its 64/IN_W-th word. Cycles with word_valid_i low leave the partial block unchanged.
- R3: ct_o equals the standard DES encryption of the gathered block under the loaded key. Key bit 63 and block bit 63 are the first bits of the standard's numbering.
- R4: A ciphertext appears with ct_valid_o high after the 16th rising edge, counting the edge that accepts the block's last word as the first.
- R5: With IN_W of 64, blocks offered on consecutive cycles leave on consecutive cycles and in the same order, with sixteen blocks in flight at once.
- R6: ct_valid_o pulses exactly once for each launched block and never otherwise. Between stages, a block's valid flag moves forward by exactly one stage per clock.
- R7: The lowest bit of each key byte (bits 56, 48, 40, 32, 24, 16, 8 and 0) has no effect on the ciphertext.
- R8: key_load_i captures key_i at a rising edge, and the derived round keys stay in use for every later block until the next load. A load is issued only while no block is in flight and none is being launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| key_load_i | input | 1 | Strobe that captures key_i and derives the round keys |
| key_i | input | 64 | Cipher key, parity bits included |
| word_valid_i | input | 1 | word_i carries the next plaintext word |
| word_i | input | IN_W | Plaintext word, most-significant word first |
| ct_valid_o | output | 1 | ct_o carries a ciphertext this cycle |
| ct_o | output | 64 | Ciphertext, zero when ct_valid_o is low |

## Verification
The bench builds two copies of the block. One has IN_W = 8, which exercises word packing order, idle gaps between words and a reset that cuts a block short. The other has IN_W = 64, which is the only setting that can launch a block on every clock. That copy fills all sixteen stages and shows back-to-back output. Both copies run known-answer vectors under several keys, including keys that differ only in their parity bits.

// File: rtl/des_pkg.sv
package des_pkg;

  localparam int unsigned BLK_W      = 64;
  localparam int unsigned HALF_W     = BLK_W / 2;
  localparam int unsigned RK_W       = 48;
  localparam int unsigned CD_W       = 56;
  localparam int unsigned SIDE_W     = CD_W / 2;
  localparam int unsigned NUM_ROUNDS = 16;
  localparam int unsigned NUM_SBOX   = 8;

  typedef logic [BLK_W-1:0]  blk_t;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [RK_W-1:0]   rkey_t;
  typedef logic [CD_W-1:0]   cd_t;
  typedef logic [SIDE_W-1:0] side_t;

  // 64 nibbles per box, entry index row*16+col, entry 0 in the top nibble
  localparam logic [255:0] SBOX [NUM_SBOX] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
  };

  // tables hold 1-based source positions, position 1 = MSB
  localparam byte unsigned P_TAB [HALF_W] = '{
    16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
    2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25
  };

  localparam byte unsigned PC1_TAB [CD_W] = '{
    57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18,
    10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
    14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4
  };

  localparam byte unsigned PC2_TAB [RK_W] = '{
    14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
    23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
  };

  // rounds (bit = round-1) that rotate by one instead of two
  localparam logic [NUM_ROUNDS-1:0] SINGLE_ROT = 16'h8103;

  function automatic int unsigned ip_src(int unsigned i);
    int unsigned r;
    int unsigned c;
    r = i / 8;
    c = i % 8;
    return (r < 4) ? (58 + 2 * r - 8 * c) : (57 + 2 * (r - 4) - 8 * c);
  endfunction

  function automatic blk_t init_perm(blk_t x);
    blk_t y;
    for (int i = 0; i < BLK_W; i++) y[BLK_W-1-i] = x[BLK_W-ip_src(i)];
    return y;
  endfunction

  function automatic blk_t final_perm(blk_t x);
    blk_t y;
    for (int i = 0; i < BLK_W; i++) y[BLK_W-ip_src(i)] = x[BLK_W-1-i];
    return y;
  endfunction

  function automatic rkey_t expand(half_t r);
    rkey_t e;
    int unsigned src;
    for (int j = 0; j < RK_W; j++) begin
      src = (4 * (j / 6) + (j % 6) + 31) % 32 + 1;
      e[RK_W-1-j] = r[HALF_W-src];
    end
    return e;
  endfunction

  function automatic half_t sbox_layer(rkey_t b);
    half_t o;
    logic [5:0] six;
    int unsigned k;
    for (int s = 0; s < NUM_SBOX; s++) begin
      six = b[RK_W-1-6*s -: 6];
      k = int'({six[5], six[0], six[4:1]});
      o[HALF_W-1-4*s -: 4] = SBOX[s][255-4*k -: 4];
    end
    return o;
  endfunction

  function automatic half_t p_perm(half_t x);
    half_t y;
    for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W-P_TAB[i]];
    return y;
  endfunction

  function automatic blk_t feistel_round(blk_t lr, rkey_t k);
    half_t l;
    half_t r;
    l = lr[BLK_W-1:HALF_W];
    r = lr[HALF_W-1:0];
    return {r, l ^ p_perm(sbox_layer(expand(r) ^ k))};
  endfunction

  function automatic cd_t key_pc1(blk_t key);
    cd_t cd;
    for (int i = 0; i < CD_W; i++) cd[CD_W-1-i] = key[BLK_W-PC1_TAB[i]];
    return cd;
  endfunction

  function automatic rkey_t key_pc2(cd_t cd);
    rkey_t k;
    for (int i = 0; i < RK_W; i++) k[RK_W-1-i] = cd[CD_W-PC2_TAB[i]];
    return k;
  endfunction

  function automatic int unsigned total_rot(int unsigned rnd);
    int unsigned sum;
    sum = 0;
    for (int j = 0; j < NUM_ROUNDS; j++)
      if (j <= int'(rnd)) sum += SINGLE_ROT[j] ? 1 : 2;
    return sum;
  endfunction

  function automatic side_t rotl(side_t v, int unsigned n);
    return (v << n) | (v >> (SIDE_W - n));
  endfunction

  // rnd is 0-based
  function automatic rkey_t round_key(blk_t key, int unsigned rnd);
    cd_t cd;
    int unsigned n;
    cd = key_pc1(key);
    n  = total_rot(rnd);
    return key_pc2({rotl(cd[CD_W-1:SIDE_W], n), rotl(cd[SIDE_W-1:0], n)});
  endfunction

endpackage

// File: rtl/des_word_gather.sv
module des_word_gather
  import des_pkg::*;
#(
  parameter int unsigned IN_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            word_valid_i,
  input  logic [IN_W-1:0] word_i,
  output logic            blk_valid_o,
  output blk_t            blk_o
);

  localparam int unsigned BEATS  = BLK_W / IN_W;
  localparam int unsigned CNT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int unsigned HOLD_W = (BEATS > 1) ? BLK_W - IN_W : 1;

  if (BEATS == 1) begin : g_direct
    assign blk_valid_o = word_valid_i;
    assign blk_o       = blk_t'(word_i);
  end else begin : g_pack
    logic [CNT_W-1:0]  cnt_q;
    logic [HOLD_W-1:0] hold_q;
    logic              last_beat;

    assign last_beat   = (cnt_q == CNT_W'(BEATS - 1));
    assign blk_valid_o = word_valid_i & last_beat;
    assign blk_o       = {hold_q, word_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        hold_q <= '0;
      end else if (word_valid_i) begin
        cnt_q  <= last_beat ? '0 : cnt_q + 1'b1;
        hold_q <= HOLD_W'({hold_q, word_i});
      end
    end

    assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blk_valid_o |=> (cnt_q == '0));
    assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !word_valid_i |=> $stable(cnt_q) && $stable(hold_q));
  end

endmodule

// File: rtl/des_key_sched.sv
module des_key_sched
  import des_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           load_i,
  input  blk_t                           key_i,
  output rkey_t [NUM_ROUNDS-1:0]         rkey_o
);

  for (genvar g = 0; g < NUM_ROUNDS; g++) begin : g_rk
    rkey_t rk_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     rk_q <= '0;
      else if (load_i) rk_q <= round_key(key_i, g);
    end

    assign rkey_o[g] = rk_q;
  end

endmodule

// File: rtl/des_round_stage.sv
module des_round_stage
  import des_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  blk_t  blk_i,
  input  rkey_t rkey_i,
  output logic  valid_o,
  output blk_t  blk_o
);

  logic valid_q;
  blk_t blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  // data carries no reset; downstream qualifies it with valid
  always_ff @(posedge clk_i) begin
    if (valid_i) blk_q <= feistel_round(blk_i, rkey_i);
  end

  assign valid_o = valid_q;
  assign blk_o   = blk_q;

  assert_advance_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_bubble_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

endmodule

// File: rtl/des_pipe_engine.sv
module des_pipe_engine
  import des_pkg::*;
#(
  parameter int unsigned IN_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            key_load_i,
  input  logic [63:0]     key_i,
  input  logic            word_valid_i,
  input  logic [IN_W-1:0] word_i,
  output logic            ct_valid_o,
  output logic [63:0]     ct_o
);

  logic                   in_valid;
  blk_t                   in_blk;
  rkey_t [NUM_ROUNDS-1:0] rkeys;
  logic [NUM_ROUNDS:0]    stage_valid;
  blk_t                   stage_blk [NUM_ROUNDS+1];
  blk_t                   last_blk;

  des_word_gather #(.IN_W(IN_W)) u_gather (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_valid_i (word_valid_i),
    .word_i       (word_i),
    .blk_valid_o  (in_valid),
    .blk_o        (in_blk)
  );

  des_key_sched u_keys (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (key_load_i),
    .key_i  (key_i),
    .rkey_o (rkeys)
  );

  assign stage_valid[0] = in_valid;
  assign stage_blk[0]   = init_perm(in_blk);

  for (genvar s = 0; s < NUM_ROUNDS; s++) begin : g_round
    des_round_stage u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (stage_valid[s]),
      .blk_i   (stage_blk[s]),
      .rkey_i  (rkeys[s]),
      .valid_o (stage_valid[s+1]),
      .blk_o   (stage_blk[s+1])
    );
  end

  // last round output is swapped before the final permutation
  assign last_blk   = stage_blk[NUM_ROUNDS];
  assign ct_valid_o = stage_valid[NUM_ROUNDS];
  assign ct_o       = ct_valid_o
                    ? final_perm({last_blk[HALF_W-1:0], last_blk[BLK_W-1:HALF_W]})
                    : '0;

  assert_key_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_load_i |-> !(|stage_valid));
  assert_quiet_out_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ct_valid_o |-> (ct_o == '0));

endmodule

// File: tb/des_pipe_engine_tb_top.sv
`timescale 1ns/1ps
module des_pipe_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_ld = 1'b0;
  logic [63:0] key = '0;
  logic        wv_n = 1'b0;
  logic [7:0]  w_n = '0;
  logic        wv_w = 1'b0;
  logic [63:0] w_w = '0;
  logic        ctv_n, ctv_w;
  logic [63:0] ct_n, ct_w;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  des_pipe_engine #(.IN_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .key_load_i(key_ld), .key_i(key),
    .word_valid_i(wv_n), .word_i(w_n), .ct_valid_o(ctv_n), .ct_o(ct_n)
  );

  des_pipe_engine #(.IN_W(64)) dut_wide_i (
    .clk_i(clk), .rst_ni(rst_n), .key_load_i(key_ld), .key_i(key),
    .word_valid_i(wv_w), .word_i(w_w), .ct_valid_o(ctv_w), .ct_o(ct_w)
  );

  localparam int NV = 10;
  localparam logic [63:0] VK [NV] = '{
    64'h133457799BBCDFF1, 64'h0E329232EA6D0D73, 64'h0123456789ABCDEF,
    64'h0101010101010101, 64'h0101010101010101, 64'h0101010101010101,
    64'h0101010101010101, 64'h0000000000000000, 64'h0000000000000000,
    64'hFEFEFEFEFEFEFEFE
  };
  localparam logic [63:0] VP [NV] = '{
    64'h0123456789ABCDEF, 64'h8787878787878787, 64'h4E6F772069732074,
    64'h95F8A5E5DD31D900, 64'hDD7F121CA5015619, 64'h2E8653104F3834EA,
    64'h55579380D77138EF, 64'h4BD388FF6CD81D4F, 64'h0000000000000000,
    64'hFFFFFFFFFFFFFFFF
  };
  localparam logic [63:0] VC [NV] = '{
    64'h85E813540F0AB405, 64'h0000000000000000, 64'h3FA40E8A984D4815,
    64'h8000000000000000, 64'h4000000000000000, 64'h2000000000000000,
    64'h0400000000000000, 64'h1000000000000000, 64'h8CA64DE9C1B123A7,
    64'h7359B2163E4EDC58
  };

  logic [63:0] exp_n_q [$];
  int          iss_n_q [$];
  string       tag_n_q [$];
  logic [63:0] exp_w_q [$];
  int          iss_w_q [$];
  string       tag_w_q [$];
  int          out_w_stamp [$];

  logic [63:0] mon_e;
  int          mon_s;
  string       mon_t;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && ctv_n) begin
      if (exp_n_q.size() == 0) check("R6 narrow spurious valid", 64'd1, 64'd0);
      else begin
        mon_e = exp_n_q.pop_front();
        mon_s = iss_n_q.pop_front();
        mon_t = tag_n_q.pop_front();
        check({mon_t, " narrow ciphertext"}, ct_n, mon_e);
        check("R4 narrow latency", 64'(cyc - mon_s), 64'd15);
      end
    end
    if (rst_n && ctv_w) begin
      out_w_stamp.push_back(cyc);
      if (exp_w_q.size() == 0) check("R6 wide spurious valid", 64'd1, 64'd0);
      else begin
        mon_e = exp_w_q.pop_front();
        mon_s = iss_w_q.pop_front();
        mon_t = tag_w_q.pop_front();
        check({mon_t, " wide ciphertext"}, ct_w, mon_e);
        check("R4 wide latency", 64'(cyc - mon_s), 64'd15);
      end
    end
  end

  task automatic load_key(input logic [63:0] k);
    key_ld = 1'b1;
    key = k;
    @(posedge clk); @(negedge clk);
    key_ld = 1'b0;
  endtask

  task automatic send_narrow(input logic [63:0] pt, input logic [63:0] ct,
                             input string tag, input int gap);
    for (int b = 0; b < 8; b++) begin
      wv_n = 1'b1;
      w_n  = pt[63-8*b -: 8];
      @(posedge clk); @(negedge clk);
      wv_n = 1'b0;
      if (b == 7) begin
        exp_n_q.push_back(ct); iss_n_q.push_back(cyc); tag_n_q.push_back(tag);
      end
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic send_wide(input logic [63:0] pt, input logic [63:0] ct, input string tag);
    wv_w = 1'b1;
    w_w  = pt;
    @(posedge clk); @(negedge clk);
    wv_w = 1'b0;
    exp_w_q.push_back(ct); iss_w_q.push_back(cyc); tag_w_q.push_back(tag);
  endtask

  task automatic drain();
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] cur_key;
    string       tag;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 64'(ctv_n), 64'd0);
    check("R1 ct in reset", ct_n, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid after reset", 64'(ctv_n), 64'd0);
    check("R1 ct after reset", ct_n, 64'd0);
    check("R1 wide valid after reset", 64'(ctv_w), 64'd0);
    check("R1 wide ct after reset", ct_w, 64'd0);

    // R1: a partial block is dropped by reset
    load_key(VK[0]);
    for (int b = 0; b < 3; b++) begin
      wv_n = 1'b1; w_n = 8'hA5 ^ 8'(b);
      @(posedge clk); @(negedge clk);
    end
    wv_n = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    load_key(VK[0]);
    // R2: idle gaps between words
    send_narrow(VP[0], VC[0], "R1 R2 R3", 2);
    drain();
    cur_key = VK[0];

    // known-answer table
    for (int i = 1; i < NV; i++) begin
      if (VK[i] != cur_key) begin
        drain();
        load_key(VK[i]);
        cur_key = VK[i];
      end
      tag = (i >= 7) ? "R7" : (i >= 4) ? "R8" : "R3";
      send_wide(VP[i], VC[i], tag);
      send_narrow(VP[i], VC[i], tag, i % 2);
    end
    drain();

    // R5: sixteen back-to-back blocks on the wide copy
    load_key(64'h0101010101010101);
    out_w_stamp.delete();
    for (int i = 0; i < 16; i++) begin
      wv_w = 1'b1;
      w_w  = VP[3 + (i % 4)];
      @(posedge clk); @(negedge clk);
      exp_w_q.push_back(VC[3 + (i % 4)]); iss_w_q.push_back(cyc); tag_w_q.push_back("R5");
    end
    wv_w = 1'b0;
    drain();
    check("R5 burst output count", 64'(out_w_stamp.size()), 64'd16);
    if (out_w_stamp.size() == 16)
      check("R5 burst consecutive", 64'(out_w_stamp[15] - out_w_stamp[0]), 64'd15);

    // R6: nothing pending, nothing extra
    check("R6 narrow pending", 64'(exp_n_q.size()), 64'd0);
    check("R6 wide pending", 64'(exp_w_q.size()), 64'd0);
    check("R6 idle valid", 64'(ctv_n | ctv_w), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule